// File: doc/BRIEF.md
# Flag-Setting ALU with Branch Condition Evaluator

This block is the purely combinational arithmetic and logic stage of a small processor with four registers. From a 4-bit opcode and two data operands (the destination register value `opa` and the source register value `opb`) it computes a result, tells the core whether to write that result back, and produces the next values of the zero, negative, carry and overflow flags together with a strobe that says whether the flags should be updated at all.

Alongside the arithmetic path, a separate evaluator reads the flags currently held by the core and a 3-bit condition selector, and produces a branch-taken signal. The flag register, the register file, fetch and memory access all live in the surrounding core. Subtract and compare use the "no borrow" sense of carry, so `C=1` means `opa >= opb` unsigned. The data width is a parameter that defaults to 8 bits.

Top module: `alu_flags`

## Requirements
- R1: Opcode 0x0 (add) gives result = (opa+opb) mod 2^W, and C is the carry out of the top bit. For example, 255+1 gives 0 with C=1, and 1+1 gives 2 with C=0.
- R2: Opcodes 0x1 (sub) and 0x9 (cmp) give result = (opa-opb) mod 2^W. C=1 exactly when opa >= opb unsigned, so 0-1 gives 0xFF with C=0.
- R3: V reports signed two's-complement overflow for add, sub and cmp. For example, 127+1 gives V=1 and 1+1 gives V=0. Opcodes 0x2 to 0x7 clear V.
- R4: For every opcode 0x0 to 0x9, Z = (result == 0) and N = the top bit of the result. For cmp this applies to the difference.
- R5: wr_en is 1 for opcodes 0x0 to 0x8 and 0 for cmp (0x9). flag_upd is 1 for opcodes 0x0 to 0x9.
- R6: Opcodes 0x2, 0x3 and 0x4 give the bitwise and, or and xor of opa and opb, with C=0.
- R7: Opcode 0x5 shifts opa left by one bit and opcode 0x6 shifts it right by one bit. Both fill with 0 and ignore opb. C takes the bit shifted out: opa[W-1] for a left shift, opa[0] for a right shift.
- R8: Opcode 0x7 gives the low W bits of opa*opb, with C=0 and V=0.
- R9: Opcode 0x8 gives the truncated quotient opa/opb with C=0 and V=0. When opb=0 it gives all ones with V=1.
- R10: br_taken depends only on cond_sel and the flag inputs. The selector codes 0 to 7 mean Z, !Z, C, !C, N, !N, V and !V, in that order.
- R11: Opcodes 0xA to 0xF give result 0, wr_en=0 and flag_upd=0. Each next-flag output then equals its flag input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opa | input | W | Destination register value (first operand) |
| opb | input | W | Source register value (second operand) |
| cond_sel | input | 3 | Branch condition selector |
| z_in | input | 1 | Current zero flag |
| n_in | input | 1 | Current negative flag |
| c_in | input | 1 | Current carry flag |
| v_in | input | 1 | Current overflow flag |
| result | output | W | Operation result |
| wr_en | output | 1 | Write result to the destination register |
| z_nxt | output | 1 | Next zero flag |
| n_nxt | output | 1 | Next negative flag |
| c_nxt | output | 1 | Next carry flag |
| v_nxt | output | 1 | Next overflow flag |
| flag_upd | output | 1 | Flags should load the next values |
| br_taken | output | 1 | Selected branch condition holds |

## Verification
The bench builds the block with the default width W=8. At that width the whole operand space is small enough that directed vectors reach every edge case the requirements name: the carry out of 255+1, the signed overflow of 127+1, the borrow of 0-1, the bits shifted out of 0x80 and 0x01, division by zero, and each of the six unused opcodes. A behavioural model built on integers checks directed and random vectors, including all sixteen opcodes, against each output. It also checks all eight condition codes with every flag combination, while the opcode keeps changing.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0,
    OP_SUB = 4'h1,
    OP_AND = 4'h2,
    OP_OR  = 4'h3,
    OP_XOR = 4'h4,
    OP_SHL = 4'h5,
    OP_SHR = 4'h6,
    OP_MUL = 4'h7,
    OP_DIV = 4'h8,
    OP_CMP = 4'h9
  } alu_op_e;

  typedef enum logic [2:0] {
    CC_Z  = 3'd0,
    CC_NZ = 3'd1,
    CC_C  = 3'd2,
    CC_NC = 3'd3,
    CC_N  = 3'd4,
    CC_NN = 3'd5,
    CC_V  = 3'd6,
    CC_NV = 3'd7
  } cond_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  // Signed overflow: both addends share a sign that the sum lacks.
  function automatic logic f_ovf(input logic a_msb, input logic b_msb,
                                 input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // Opcode carries a write-back to the destination register.
  function automatic logic f_writes(input logic [3:0] code);
    return code <= 4'h8;
  endfunction

  // Opcode belongs to the ALU group and so updates flags.
  function automatic logic f_updates(input logic [3:0] code);
    return code <= 4'h9;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  import alu_pkg::*;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  // Subtract as a + ~b + 1; carry out is then the no-borrow indication.
  assign b_eff = sub ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = wide[W-1:0];
  assign carry = wide[W];
  assign ovf   = f_ovf(a[W-1], b_eff[W-1], sum[W-1]);

  always_comb begin
    if (sub) begin
      p_noborrow_r2: assert (carry == (a >= b))
        else $error("no-borrow carry mismatch");
    end
  end

endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod
);

  logic [W-1:0] acc [0:W];

  assign acc[0] = '0;

  // Shift-and-add chain, truncated to W bits at every stage.
  for (genvar k = 0; k < W; k++) begin : g_pp
    logic [W-1:0] pp;
    assign pp         = b[k] ? (a << k) : '0;
    assign acc[k + 1] = acc[k] + pp;
  end

  assign prod = acc[W];

endmodule

// File: rtl/alu_div.sv
module alu_div #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] quo,
  output logic         div_zero
);

  logic [W-1:0] part [0:W-1];
  logic [W-1:0] q_raw;

  assign part[0]  = '0;
  assign div_zero = (b == '0);

  // Restoring division, one quotient bit per stage, MSB first.
  for (genvar k = 0; k < W; k++) begin : g_stage
    localparam int IDX = W - 1 - k;
    logic [W:0]   shifted;
    logic [W-1:0] diff;
    logic         ge;
    assign shifted  = {part[k], a[IDX]};
    assign ge       = shifted >= {1'b0, b};
    assign diff     = shifted[W-1:0] - b;
    assign q_raw[IDX] = ge;
    if (k < W - 1) begin : g_next
      assign part[k + 1] = ge ? diff : shifted[W-1:0];
    end
  end

  assign quo = div_zero ? '1 : q_raw;

  always_comb begin
    if (!div_zero) begin
      p_quot_bound_r9: assert ((W'(quo) * W'(1) <= a) && (quo <= a))
        else $error("quotient exceeds dividend");
    end
  end

endmodule

// File: rtl/alu_cond.sv
module alu_cond (
  input  logic [2:0]      sel,
  input  alu_pkg::flags_t cur,
  output logic            taken
);
  import alu_pkg::*;

  logic picked;

  // Even codes test a flag, the odd code above tests its complement.
  always_comb begin
    unique case (sel[2:1])
      2'd0:    picked = cur.z;
      2'd1:    picked = cur.c;
      2'd2:    picked = cur.n;
      default: picked = cur.v;
    endcase
  end

  assign taken = picked ^ sel[0];

  always_comb begin
    if (cond_e'(sel) == CC_Z) begin
      p_cond_z_r10: assert (taken == cur.z) else $error("JZ mismatch");
    end
    if (cond_e'(sel) == CC_NV) begin
      p_cond_nv_r10: assert (taken == !cur.v) else $error("JNV mismatch");
    end
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   cond_sel,
  input  logic         z_in,
  input  logic         n_in,
  input  logic         c_in,
  input  logic         v_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         z_nxt,
  output logic         n_nxt,
  output logic         c_nxt,
  output logic         v_nxt,
  output logic         flag_upd,
  output logic         br_taken
);
  import alu_pkg::*;

  flags_t       cur_flags;
  logic         is_sub;
  logic [W-1:0] as_res;
  logic         as_carry;
  logic         as_ovf;
  logic [W-1:0] mul_res;
  logic [W-1:0] div_res;
  logic         div_zero;
  logic [W-1:0] core_res;
  logic         core_c;
  logic         core_v;
  logic         ev_alu_op;

  assign cur_flags = '{z: z_in, n: n_in, c: c_in, v: v_in};
  assign is_sub    = (op == OP_SUB) || (op == OP_CMP);
  assign ev_alu_op = f_updates(op);

  alu_addsub #(.W(W)) u_addsub (
    .a(opa), .b(opb), .sub(is_sub),
    .sum(as_res), .carry(as_carry), .ovf(as_ovf)
  );

  alu_mul #(.W(W)) u_mul (
    .a(opa), .b(opb), .prod(mul_res)
  );

  alu_div #(.W(W)) u_div (
    .a(opa), .b(opb), .quo(div_res), .div_zero(div_zero)
  );

  alu_cond u_cond (
    .sel(cond_sel), .cur(cur_flags), .taken(br_taken)
  );

  always_comb begin
    core_res = '0;
    core_c   = 1'b0;
    core_v   = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_CMP: begin
        core_res = as_res;
        core_c   = as_carry;
        core_v   = as_ovf;
      end
      OP_AND: core_res = opa & opb;
      OP_OR:  core_res = opa | opb;
      OP_XOR: core_res = opa ^ opb;
      OP_SHL: begin
        core_res = {opa[W-2:0], 1'b0};
        core_c   = opa[W-1];
      end
      OP_SHR: begin
        core_res = {1'b0, opa[W-1:1]};
        core_c   = opa[0];
      end
      OP_MUL: core_res = mul_res;
      OP_DIV: begin
        core_res = div_res;
        core_v   = div_zero;
      end
      default: ;
    endcase
  end

  assign result   = core_res;
  assign wr_en    = f_writes(op);
  assign flag_upd = ev_alu_op;
  assign z_nxt    = ev_alu_op ? (core_res == '0) : z_in;
  assign n_nxt    = ev_alu_op ? core_res[W-1]    : n_in;
  assign c_nxt    = ev_alu_op ? core_c           : c_in;
  assign v_nxt    = ev_alu_op ? core_v           : v_in;

  always_comb begin
    if (op == OP_ADD) begin
      p_add_carry_r1: assert ({c_nxt, result} == ({1'b0, opa} + {1'b0, opb}))
        else $error("add carry/result mismatch");
    end
    if (op == OP_CMP) begin
      p_cmp_nowrite_r5: assert (!wr_en && flag_upd)
        else $error("compare wrote destination");
    end
    if (op == OP_AND || op == OP_OR || op == OP_XOR) begin
      p_logic_clear_r3: assert (!v_nxt && !c_nxt)
        else $error("logic op left C or V set");
    end
    if (op == OP_DIV && opb == '0) begin
      p_divzero_r9: assert (result == '1 && v_nxt)
        else $error("divide by zero not flagged");
    end
    if (op > 4'h9) begin
      p_hold_r11: assert (!wr_en && !flag_upd && z_nxt == z_in &&
                          n_nxt == n_in && c_nxt == c_in && v_nxt == v_in)
        else $error("non-ALU opcode disturbed state");
    end
  end

endmodule

// File: tb/sim_alu_flags.sv
module sim_alu_flags;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0]   op;
  logic [W-1:0] opa, opb;
  logic [2:0]   cond_sel;
  logic         z_in, n_in, c_in, v_in;
  logic [W-1:0] result;
  logic         wr_en, z_nxt, n_nxt, c_nxt, v_nxt, flag_upd, br_taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu_flags #(.W(W)) u0 (
    .op(op), .opa(opa), .opb(opb), .cond_sel(cond_sel),
    .z_in(z_in), .n_in(n_in), .c_in(c_in), .v_in(v_in),
    .result(result), .wr_en(wr_en), .z_nxt(z_nxt), .n_nxt(n_nxt),
    .c_nxt(c_nxt), .v_nxt(v_nxt), .flag_upd(flag_upd), .br_taken(br_taken)
  );

  task automatic chk(input string tag, input string what,
                     input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (op=%0h a=%0h b=%0h sel=%0d)",
               tag, what, got, exp, op, opa, opb, cond_sel);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Behavioural reference, compared against the outputs.
  task automatic compare();
    int a = int'(opa);
    int b = int'(opb);
    int o = int'(op);
    int r = 0, c = 0, v = 0, s;
    int z, n, t;
    string tg;
    case (o)
      0: begin s = a + b; r = s % 256; c = (s > 255); s = sgn(a) + sgn(b);
               v = (s > 127 || s < -128); tg = "R1"; end
      1, 9: begin r = (a - b + 256) % 256; c = (a >= b); s = sgn(a) - sgn(b);
                  v = (s > 127 || s < -128); tg = "R2"; end
      2: begin r = a & b; tg = "R6"; end
      3: begin r = a | b; tg = "R6"; end
      4: begin r = a ^ b; tg = "R6"; end
      5: begin r = (a * 2) % 256; c = (a >= 128); tg = "R7"; end
      6: begin r = a / 2; c = a % 2; tg = "R7"; end
      7: begin r = (a * b) % 256; tg = "R8"; end
      8: begin if (b == 0) begin r = 255; v = 1; end else r = a / b; tg = "R9"; end
      default: tg = "R11";
    endcase
    if (o <= 9) begin
      z = (r == 0); n = (r >= 128);
    end else begin
      z = z_in; n = n_in; c = c_in; v = v_in;
    end
    case (cond_sel)
      3'd0: t = z_in;   3'd1: t = !z_in;
      3'd2: t = c_in;   3'd3: t = !c_in;
      3'd4: t = n_in;   3'd5: t = !n_in;
      3'd6: t = v_in;   default: t = !v_in;
    endcase
    chk(tg, "result", int'(result), r);
    chk(tg, "C", int'(c_nxt), c);
    chk((o <= 9) ? "R4" : "R11", "Z", int'(z_nxt), z);
    chk((o <= 9) ? "R4" : "R11", "N", int'(n_nxt), n);
    chk((o == 8) ? "R9" : "R3", "V", int'(v_nxt), (o <= 9) ? v : int'(v_in));
    chk((o <= 9) ? "R5" : "R11", "wr_en", int'(wr_en), (o <= 8) ? 1 : 0);
    chk((o <= 9) ? "R5" : "R11", "flag_upd", int'(flag_upd), (o <= 9) ? 1 : 0);
    chk("R10", "br_taken", int'(br_taken), t);
  endtask

  task automatic apply(input int o, input int a, input int b,
                       input int sel, input int fl);
    @(posedge clk);
    #1;
    op = 4'(o); opa = W'(a); opb = W'(b); cond_sel = 3'(sel);
    {z_in, n_in, c_in, v_in} = 4'(fl);
    @(negedge clk);
    compare();
  endtask

  initial begin
    op = 4'hF; opa = '0; opb = '0; cond_sel = '0;
    {z_in, n_in, c_in, v_in} = 4'b0000;
    @(negedge clk);
    // Idle state with a non-ALU opcode: nothing written, flags held (R11).
    chk("R11", "idle wr_en", int'(wr_en), 0);
    chk("R11", "idle flag_upd", int'(flag_upd), 0);
    // R1 carry cases
    apply(0, 255, 1, 0, 0);
    apply(0, 1, 1, 0, 0);
    // R3 signed overflow
    apply(0, 127, 1, 0, 0);
    apply(1, 128, 1, 0, 0);
    // R2 borrow and equal compare
    apply(1, 0, 1, 0, 0);
    apply(9, 5, 5, 0, 0);
    apply(9, 3, 5, 0, 0);
    apply(1, 1, 1, 0, 0);
    // R6 logic with flags preset to see them cleared
    apply(2, 8'hCC, 8'hF0, 0, 4'b0011);
    apply(3, 8'hC0, 8'h0F, 0, 4'b0011);
    apply(4, 8'hCF, 8'hAA, 0, 4'b0011);
    // R7 shifts, opb must not matter
    apply(5, 8'h80, 8'hFF, 0, 0);
    apply(5, 8'h65, 8'h00, 0, 0);
    apply(6, 8'h01, 8'h37, 0, 0);
    apply(6, 8'hCA, 8'hFF, 0, 0);
    // R8 multiply
    apply(7, 17, 9, 0, 0);
    apply(7, 200, 200, 0, 4'b0011);
    // R9 divide
    apply(8, 100, 7, 0, 0);
    apply(8, 5, 9, 0, 0);
    apply(8, 255, 1, 0, 0);
    apply(8, 42, 0, 0, 0);
    // R11 every non-ALU opcode with all flags set and cleared
    for (int o = 10; o < 16; o++) begin
      apply(o, 8'h5A, 8'hA5, 0, 4'b1111);
      apply(o, 8'h00, 8'h00, 1, 4'b0000);
    end
    // R10 every selector against every flag pattern, opcode varying
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 16; f++)
        apply((s + f) % 16, f * 17, s * 31, s, f);
    // Random sweep over all opcodes
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 15), $urandom_range(0, 255),
            ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(0, 255),
            $urandom_range(0, 7), $urandom_range(0, 15));
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule